// File: doc/BRIEF.md
# Parallel ATA PIO Bus Cycle Generator

This block turns single register accesses from a synchronous host into programmed-I/O bus cycles on a parallel ATA device. The host pulses a start request with an address, a direction, write data and a byte/word flag. The block then runs one complete device cycle and pulses done in the last clock of that cycle. For a read, the returned data is valid in the same clock as done.

Each cycle has three phases in a fixed order: a setup phase, a strobe phase and a recovery phase. The length of each phase comes from timing registers counted in clock cycles. If the programmed total cycle leaves too little recovery, the block lengthens the cycle by itself. Chip select is held for a fixed margin past the strobe. While the device's ready line is low, the strobe phase is extended.

Host address bit 4 picks between the command register block and the control register block. Host address bits [3:1] form the device register address. Because of this, 8-bit registers always use the low data byte. The data bus is presented as a separate output, output enable and input, to be joined at the pad.

Top module: `pio_cycle_gen`

## Requirements
- R1: In reset and after it, both chip selects, both strobes and the ready-independent outputs are inactive: cs0_n=1, cs1_n=1, dior_n=1, diow_n=1, data_oe=0, req_done=0, req_busy=0, cfg_err=0. The timing registers reset to whole-clock roundings up of 70 ns setup, 290 ns pulse, 600 ns cycle and 15 ns hold at the clock period CLK_NS (9, 37, 75 and 2 clocks at 8 ns).
- R2: An accepted start gives setup clocks with both strobes high, then pulse clocks with the strobe low, then recovery clocks. req_busy is high for the whole cycle. req_done is high only in its last clock.
- R3: Recovery lasts the cycle register minus setup and pulse, but never less than ceil(25 ns / CLK_NS) clocks (4 at 8 ns). When the programmed cycle is too short, the cycle is lengthened to setup + pulse + that minimum.
- R4: Chip select goes low in the first clock of the cycle. It stays low for setup + pulse (including ready extension) + hold clocks, clipped at the end of the cycle. Address bit 4 = 0 drives cs0_n low with cs1_n high; bit 4 = 1 drives cs1_n low with cs0_n high.
- R5: ata_addr equals host address bits [3:1] for the whole cycle.
- R6: A write uses diow_n with the same timing a read would use. data_oe is high from the first clock until one clock after chip select rises. ata_data_o carries the write data, and a byte write drives the upper byte as zero.
- R7: A read captures ata_data_i at the clock edge that ends the strobe. A byte read returns the upper byte as zero. req_rdata is valid in the done clock.
- R8: If ata_iordy is low at the end of the last programmed pulse clock, the strobe stays low and the cycle grows by one clock per such sample, until ata_iordy is seen high.
- R9: A timing register write (cfg_sel 0 setup, 1 pulse, 2 cycle, 3 hold) is taken only when the block is idle and no start is presented in the same clock. Otherwise it is dropped and cfg_err goes high. An accepted write clears cfg_err.
- R10: A setup or pulse register value of zero acts as one clock.
- R11: A start presented while a cycle runs is ignored: the running cycle's address, direction and timing do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_start | input | 1 | Start one device access (taken when idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Host address: bit 4 block select, bits 3:1 register |
| req_wdata | input | DATA_W | Write data |
| req_byte | input | 1 | 1 = 8-bit access on the low byte |
| req_busy | output | 1 | A cycle is in progress |
| req_done | output | 1 | Last clock of the cycle |
| req_rdata | output | DATA_W | Read data, valid with req_done |
| cfg_we | input | 1 | Timing register write strobe |
| cfg_sel | input | 2 | Timing register select |
| cfg_wdata | input | CNT_W | Timing value in clocks |
| cfg_err | output | 1 | Last timing write was dropped |
| ata_cs0_n | output | 1 | Command block select, active low |
| ata_cs1_n | output | 1 | Control block select, active low |
| ata_addr | output | 3 | Device register address |
| ata_dior_n | output | 1 | Read strobe, active low |
| ata_diow_n | output | 1 | Write strobe, active low |
| ata_iordy | input | 1 | Device ready; low extends the strobe |
| ata_data_o | output | DATA_W | Data bus drive value |
| ata_data_oe | output | 1 | Data bus drive enable |
| ata_data_i | input | DATA_W | Data bus sampled value |

## Verification
The main function is exercised in several ways:
- Default-timing word reads and byte and word writes to both register blocks, to tell apart block select, direction and byte masking.
- A short cycle register that forces stretching, and a long one that does not, to separate the minimum-recovery rule from the plain cycle count.
- A ready line held low across the end of the pulse, which separates a fixed strobe from an extended one.
- Zero setup and pulse values, and a hold longer than recovery, which probe the clamping and clipping corners.
- Starts and timing writes injected mid-cycle and in the start clock, to show they leave the running cycle untouched.

// File: rtl/pio_pkg.sv
package pio_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_RECOV  = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        TSEL_SETUP = 2'd0,
        TSEL_PULSE = 2'd1,
        TSEL_CYCLE = 2'd2,
        TSEL_HOLD  = 2'd3
    } tsel_e;

    localparam int NUM_TREGS = 4;

    // registered device-side control pins
    typedef struct packed {
        logic cs0_n;
        logic cs1_n;
        logic dior_n;
        logic diow_n;
        logic oe;
        logic done;
    } pins_t;

    localparam pins_t PINS_IDLE = '{cs0_n: 1'b1, cs1_n: 1'b1, dior_n: 1'b1,
                                    diow_n: 1'b1, oe: 1'b0, done: 1'b0};

    // whole clocks needed to cover a time in ns
    function automatic int unsigned ns_to_clk(int unsigned ns, int unsigned period);
        return (ns + period - 1) / period;
    endfunction

endpackage

// File: rtl/pio_timing_regs.sv
module pio_timing_regs
    import pio_pkg::*;
#(
    parameter int CNT_W        = 8,
    parameter int CLK_NS       = 8,
    parameter int DEF_SETUP_NS = 70,
    parameter int DEF_PULSE_NS = 290,
    parameter int DEF_CYCLE_NS = 600,
    parameter int HOLD_NS      = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic [CNT_W-1:0] cfg_wdata,
    input  logic             fsm_busy,
    input  logic             req_start,
    output logic [CNT_W-1:0] setup_cyc,
    output logic [CNT_W-1:0] pulse_cyc,
    output logic [CNT_W-1:0] cycle_cyc,
    output logic [CNT_W-1:0] hold_cyc,
    output logic             cfg_err
);

    localparam logic [CNT_W-1:0] RST_SETUP = CNT_W'(ns_to_clk(DEF_SETUP_NS, CLK_NS));
    localparam logic [CNT_W-1:0] RST_PULSE = CNT_W'(ns_to_clk(DEF_PULSE_NS, CLK_NS));
    localparam logic [CNT_W-1:0] RST_CYCLE = CNT_W'(ns_to_clk(DEF_CYCLE_NS, CLK_NS));
    localparam logic [CNT_W-1:0] RST_HOLD  = CNT_W'(ns_to_clk(HOLD_NS, CLK_NS));

    typedef struct packed {
        logic [NUM_TREGS-1:0][CNT_W-1:0] t;
        logic                            err;
    } treg_st_t;

    treg_st_t st_d, st_q;
    logic     wr_ok;

    assign wr_ok = cfg_we && !fsm_busy && !req_start;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_TREGS; i++) begin
            if (wr_ok && (cfg_sel == 2'(i))) begin
                st_d.t[i] = cfg_wdata;
            end
        end
        if (cfg_we) begin
            st_d.err = !wr_ok;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.t   <= {RST_HOLD, RST_CYCLE, RST_PULSE, RST_SETUP};
            st_q.err <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign setup_cyc = st_q.t[TSEL_SETUP];
    assign pulse_cyc = st_q.t[TSEL_PULSE];
    assign cycle_cyc = st_q.t[TSEL_CYCLE];
    assign hold_cyc  = st_q.t[TSEL_HOLD];
    assign cfg_err   = st_q.err;

    // R9: a write that lands during a cycle is flagged
    assert_busy_write_flagged_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && fsm_busy) |=> cfg_err);

    // R9: a write taken while idle leaves the flag clear and the registers stable afterwards
    assert_idle_write_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !fsm_busy && !req_start) |=> !cfg_err);

    // R9: timing registers never move while a cycle is running
    assert_regs_frozen_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_busy && $past(fsm_busy)) |-> ($stable(setup_cyc) && $stable(pulse_cyc)
                                           && $stable(cycle_cyc) && $stable(hold_cyc)));

endmodule

// File: rtl/pio_cycle_fsm.sv
module pio_cycle_fsm
    import pio_pkg::*;
#(
    parameter int CNT_W        = 8,
    parameter int DATA_W       = 16,
    parameter int ADDR_W       = 5,
    parameter int CLK_NS       = 8,
    parameter int MIN_RECOV_NS = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              byte_acc,
    input  logic [CNT_W-1:0]  setup_cyc,
    input  logic [CNT_W-1:0]  pulse_cyc,
    input  logic [CNT_W-1:0]  cycle_cyc,
    input  logic [CNT_W-1:0]  hold_cyc,
    input  logic              iordy,
    input  logic [DATA_W-1:0] data_i,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              cs0_n,
    output logic              cs1_n,
    output logic [2:0]        dev_addr,
    output logic              dior_n,
    output logic              diow_n,
    output logic [DATA_W-1:0] data_o,
    output logic              data_oe
);

    localparam int CW2 = CNT_W + 2;
    localparam logic [CW2-1:0] MINR = CW2'(ns_to_clk(MIN_RECOV_NS, CLK_NS));
    localparam logic [DATA_W-1:0] LOW_MASK = DATA_W'(8'hFF);
    localparam int BLK_BIT = ADDR_W - 1;

    typedef struct packed {
        phase_e            ph;
        logic [CW2-1:0]    cnt;
        logic              wr;
        logic              blk;
        logic              bsel;
        logic [2:0]        a;
        logic [DATA_W-1:0] wd;
        logic [DATA_W-1:0] rd;
        pins_t             pins;
    } cyc_st_t;

    cyc_st_t st_d, st_q;

    logic [CW2-1:0] s_eff, p_eff, h_len, act_len, rlen, cyc_len;

    // effective phase lengths; zero setup or pulse counts as one clock (R10)
    assign s_eff   = (setup_cyc == '0) ? CW2'(1) : CW2'(setup_cyc);
    assign p_eff   = (pulse_cyc == '0) ? CW2'(1) : CW2'(pulse_cyc);
    assign h_len   = CW2'(hold_cyc);
    assign cyc_len = CW2'(cycle_cyc);
    assign act_len = s_eff + p_eff;
    // recovery stretched to the minimum when the cycle register is short (R3)
    assign rlen    = (cyc_len > act_len + MINR) ? (cyc_len - act_len) : MINR;

    function automatic pins_t pin_decode(phase_e ph, logic [CW2-1:0] c, logic w, logic b,
                                         logic [CW2-1:0] hold, logic [CW2-1:0] rl);
        pins_t p;
        logic  drive_cs;
        logic  early;
        early    = (ph == PH_SETUP) || (ph == PH_STROBE);
        drive_cs = early || ((ph == PH_RECOV) && (c < hold));
        p.cs0_n  = !(drive_cs && !b);
        p.cs1_n  = !(drive_cs && b);
        p.dior_n = !((ph == PH_STROBE) && !w);
        p.diow_n = !((ph == PH_STROBE) && w);
        p.oe     = w && (early || ((ph == PH_RECOV) && (c < hold + CW2'(1))));
        p.done   = (ph == PH_RECOV) && (c == rl - CW2'(1));
        return p;
    endfunction

    always_comb begin
        st_d = st_q;
        unique case (st_q.ph)
            PH_IDLE: begin
                if (start) begin
                    st_d.ph   = PH_SETUP;
                    st_d.cnt  = '0;
                    st_d.wr   = wr;
                    st_d.blk  = addr[BLK_BIT];
                    st_d.a    = addr[3:1];
                    st_d.bsel = byte_acc;
                    st_d.wd   = byte_acc ? (wdata & LOW_MASK) : wdata;
                end
            end
            PH_SETUP: begin
                if (st_q.cnt == s_eff - CW2'(1)) begin
                    st_d.ph  = PH_STROBE;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + CW2'(1);
                end
            end
            PH_STROBE: begin
                if (st_q.cnt == p_eff - CW2'(1)) begin
                    // ready low holds the strobe and the count (R8)
                    if (iordy) begin
                        st_d.ph  = PH_RECOV;
                        st_d.cnt = '0;
                        if (!st_q.wr) begin
                            st_d.rd = st_q.bsel ? (data_i & LOW_MASK) : data_i;
                        end
                    end
                end else begin
                    st_d.cnt = st_q.cnt + CW2'(1);
                end
            end
            PH_RECOV: begin
                if (st_q.cnt == rlen - CW2'(1)) begin
                    st_d.ph  = PH_IDLE;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + CW2'(1);
                end
            end
            default: st_d.ph = PH_IDLE;
        endcase
        st_d.pins = pin_decode(st_d.ph, st_d.cnt, st_d.wr, st_d.blk, h_len, rlen);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.pins <= PINS_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy     = (st_q.ph != PH_IDLE);
    assign done     = st_q.pins.done;
    assign rdata    = st_q.rd;
    assign cs0_n    = st_q.pins.cs0_n;
    assign cs1_n    = st_q.pins.cs1_n;
    assign dior_n   = st_q.pins.dior_n;
    assign diow_n   = st_q.pins.diow_n;
    assign data_oe  = st_q.pins.oe;
    assign dev_addr = st_q.a;
    assign data_o   = st_q.wd;

    // ---------------- assertions ----------------
    logic           strobe_any;
    logic [CW2-1:0] gap_q;

    assign strobe_any = !dior_n || !diow_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= '1;
        end else if (strobe_any) begin
            gap_q <= '0;
        end else if (gap_q != '1) begin
            gap_q <= gap_q + CW2'(1);
        end
    end

    assert_strobe_within_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_any |-> (!cs0_n || !cs1_n));

    assert_single_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({!cs0_n, !cs1_n}) <= 1);

    assert_strobes_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(!dior_n && !diow_n));

    assert_done_one_clock_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_only_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    assert_no_drive_on_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> dior_n);

    assert_recovery_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_any && !$past(strobe_any)) |-> (gap_q >= MINR));

    assert_addr_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(dev_addr));

endmodule

// File: rtl/pio_cycle_gen.sv
module pio_cycle_gen
    import pio_pkg::*;
#(
    parameter int CNT_W        = 8,
    parameter int DATA_W       = 16,
    parameter int ADDR_W       = 5,
    parameter int CLK_NS       = 8,
    parameter int MIN_RECOV_NS = 25,
    parameter int HOLD_NS      = 15,
    parameter int DEF_SETUP_NS = 70,
    parameter int DEF_PULSE_NS = 290,
    parameter int DEF_CYCLE_NS = 600
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_start,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_byte,
    output logic              req_busy,
    output logic              req_done,
    output logic [DATA_W-1:0] req_rdata,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [CNT_W-1:0]  cfg_wdata,
    output logic              cfg_err,
    output logic              ata_cs0_n,
    output logic              ata_cs1_n,
    output logic [2:0]        ata_addr,
    output logic              ata_dior_n,
    output logic              ata_diow_n,
    input  logic              ata_iordy,
    output logic [DATA_W-1:0] ata_data_o,
    output logic              ata_data_oe,
    input  logic [DATA_W-1:0] ata_data_i
);

    logic [CNT_W-1:0] setup_cyc, pulse_cyc, cycle_cyc, hold_cyc;
    logic             fsm_busy;

    pio_timing_regs #(
        .CNT_W       (CNT_W),
        .CLK_NS      (CLK_NS),
        .DEF_SETUP_NS(DEF_SETUP_NS),
        .DEF_PULSE_NS(DEF_PULSE_NS),
        .DEF_CYCLE_NS(DEF_CYCLE_NS),
        .HOLD_NS     (HOLD_NS)
    ) u_tregs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_sel  (cfg_sel),
        .cfg_wdata(cfg_wdata),
        .fsm_busy (fsm_busy),
        .req_start(req_start),
        .setup_cyc(setup_cyc),
        .pulse_cyc(pulse_cyc),
        .cycle_cyc(cycle_cyc),
        .hold_cyc (hold_cyc),
        .cfg_err  (cfg_err)
    );

    pio_cycle_fsm #(
        .CNT_W       (CNT_W),
        .DATA_W      (DATA_W),
        .ADDR_W      (ADDR_W),
        .CLK_NS      (CLK_NS),
        .MIN_RECOV_NS(MIN_RECOV_NS)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (req_start),
        .wr       (req_write),
        .addr     (req_addr),
        .wdata    (req_wdata),
        .byte_acc (req_byte),
        .setup_cyc(setup_cyc),
        .pulse_cyc(pulse_cyc),
        .cycle_cyc(cycle_cyc),
        .hold_cyc (hold_cyc),
        .iordy    (ata_iordy),
        .data_i   (ata_data_i),
        .busy     (fsm_busy),
        .done     (req_done),
        .rdata    (req_rdata),
        .cs0_n    (ata_cs0_n),
        .cs1_n    (ata_cs1_n),
        .dev_addr (ata_addr),
        .dior_n   (ata_dior_n),
        .diow_n   (ata_diow_n),
        .data_o   (ata_data_o),
        .data_oe  (ata_data_oe)
    );

    assign req_busy = fsm_busy;

endmodule

// File: tb/pio_cycle_gen_tb.sv
module pio_cycle_gen_tb;

    localparam int CLK_NS = 8;
    localparam int MINR   = (25 + CLK_NS - 1) / CLK_NS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_start = 1'b0, req_write = 1'b0, req_byte = 1'b0;
    logic [4:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_busy, req_done;
    logic [15:0] req_rdata;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        cfg_err;
    logic        ata_cs0_n, ata_cs1_n, ata_dior_n, ata_diow_n, ata_data_oe;
    logic [2:0]  ata_addr;
    logic        ata_iordy = 1'b1;
    logic [15:0] ata_data_o;
    logic [15:0] ata_data_i = 16'h0000;

    int n_chk = 0;
    int n_err = 0;
    bit fin = 1'b0;

    always #4 clk = ~clk;

    pio_cycle_gen u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_start(req_start), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_byte(req_byte),
        .req_busy(req_busy), .req_done(req_done), .req_rdata(req_rdata),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_err(cfg_err),
        .ata_cs0_n(ata_cs0_n), .ata_cs1_n(ata_cs1_n), .ata_addr(ata_addr),
        .ata_dior_n(ata_dior_n), .ata_diow_n(ata_diow_n), .ata_iordy(ata_iordy),
        .ata_data_o(ata_data_o), .ata_data_oe(ata_data_oe), .ata_data_i(ata_data_i)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int          m_reg [4];
    bit          m_busy, m_err, m_wr, m_blk, m_byte, m_idle_before;
    int          m_t, m_S, m_P, m_H, m_T, m_wait;
    logic [2:0]  m_a;
    logic [15:0] m_wd, m_rd;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_reg[0] = (70 + CLK_NS - 1) / CLK_NS;
            m_reg[1] = (290 + CLK_NS - 1) / CLK_NS;
            m_reg[2] = (600 + CLK_NS - 1) / CLK_NS;
            m_reg[3] = (15 + CLK_NS - 1) / CLK_NS;
            m_busy = 0; m_err = 0; m_t = 0; m_wait = 0; m_rd = '0; m_a = '0; m_wd = '0;
        end else begin
            m_idle_before = !m_busy;
            if (cfg_we) begin
                if (m_idle_before && !req_start) begin
                    m_reg[cfg_sel] = int'(cfg_wdata);
                    m_err = 0;
                end else begin
                    m_err = 1;
                end
            end
            if (m_busy) begin
                if (m_t == m_S + m_P - 1 + m_wait) begin
                    if (!ata_iordy) m_wait++;
                    else if (!m_wr) m_rd = m_byte ? {8'h00, ata_data_i[7:0]} : ata_data_i;
                end
                m_t++;
                if (m_t >= m_T + m_wait) m_busy = 0;
            end else if (req_start) begin
                m_wr   = req_write;
                m_blk  = req_addr[4];
                m_a    = req_addr[3:1];
                m_byte = req_byte;
                m_wd   = req_byte ? {8'h00, req_wdata[7:0]} : req_wdata;
                m_S    = (m_reg[0] == 0) ? 1 : m_reg[0];
                m_P    = (m_reg[1] == 0) ? 1 : m_reg[1];
                m_H    = m_reg[3];
                m_T    = (m_reg[2] > m_S + m_P + MINR) ? m_reg[2] : m_S + m_P + MINR;
                m_t    = 0;
                m_wait = 0;
                m_busy = 1;
            end
        end
    end

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !fin) begin
            bit e_cs, e_strobe, e_oe, e_done;
            int pend;
            pend     = m_S + m_P + m_wait;
            e_strobe = m_busy && (m_t >= m_S) && (m_t < pend);
            e_cs     = m_busy && (m_t < pend + m_H);
            e_oe     = m_busy && m_wr && (m_t < pend + m_H + 1);
            e_done   = m_busy && (m_t == m_T + m_wait - 1);
            chk("R2", "busy", req_busy, m_busy);
            chk("R2", "done", req_done, e_done);
            chk("R2", "dior_n", ata_dior_n, !(e_strobe && !m_wr));
            chk("R6", "diow_n", ata_diow_n, !(e_strobe && m_wr));
            chk("R4", "cs0_n", ata_cs0_n, !(e_cs && !m_blk));
            chk("R4", "cs1_n", ata_cs1_n, !(e_cs && m_blk));
            chk("R6", "data_oe", ata_data_oe, e_oe);
            chk("R9", "cfg_err", cfg_err, m_err);
            if (m_busy) chk("R5", "addr", ata_addr, m_a);
            if (e_oe) chk("R6", "data_o", ata_data_o, m_wd);
            if (e_done && !m_wr) chk("R7", "rdata", req_rdata, m_rd);
        end
    end

    // ---------------- stimulus ----------------
    task automatic cfg_write(input logic [1:0] sel, input logic [7:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_access(input bit wr, input logic [4:0] addr, input logic [15:0] wd,
                             input bit byt, input int waitn, input bit poke, input bit cfg_same);
        int  k;
        int  wcnt;
        bit  armed;
        @(negedge clk);
        req_start = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd; req_byte = byt;
        if (cfg_same) begin
            cfg_we = 1'b1; cfg_sel = 2'd2; cfg_wdata = 8'd3;
        end
        @(negedge clk);
        req_start = 1'b0; cfg_we = 1'b0;
        k = 1; wcnt = 0; armed = 1'b0;
        while (m_busy) begin
            if (poke && k == 3) begin
                req_start = 1'b1; req_addr = 5'h1C; req_write = !wr;
                cfg_we = 1'b1; cfg_sel = 2'd2; cfg_wdata = 8'd5;
            end else begin
                req_start = 1'b0; cfg_we = 1'b0;
            end
            if (waitn > 0 && !armed && m_t == m_S) begin
                armed = 1'b1; wcnt = waitn;
            end
            if (wcnt > 0) begin
                ata_iordy = 1'b0; wcnt--;
            end else begin
                ata_iordy = 1'b1;
            end
            @(negedge clk);
            k++;
        end
        req_start = 1'b0; cfg_we = 1'b0; ata_iordy = 1'b1;
    endtask

    task automatic finish_run;
        fin = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: pins inactive while reset is held
        chk("R1", "reset cs0_n", ata_cs0_n, 1'b1);
        chk("R1", "reset cs1_n", ata_cs1_n, 1'b1);
        chk("R1", "reset strobes", {ata_dior_n, ata_diow_n}, 2'b11);
        chk("R1", "reset oe/done/busy/err", {ata_data_oe, req_done, req_busy, cfg_err}, 4'b0000);
        rst_n = 1'b1;
        // R1, R2, R5, R7: default timing word read, command block status register
        ata_data_i = 16'hBEEF;
        do_access(1'b0, 5'h0E, 16'h0, 1'b0, 0, 1'b0, 1'b0);
        // R6: byte write to control block register 6, upper byte must be driven zero
        do_access(1'b1, 5'h1C, 16'h12AB, 1'b1, 0, 1'b0, 1'b0);
        // R3: short cycle register stretched to setup+pulse+minimum recovery
        cfg_write(2'd0, 8'd3);
        cfg_write(2'd1, 8'd4);
        cfg_write(2'd2, 8'd10);
        cfg_write(2'd3, 8'd2);
        ata_data_i = 16'h5A77;
        do_access(1'b0, 5'h04, 16'h0, 1'b1, 0, 1'b0, 1'b0);   // R7 byte read
        // R3: long cycle register used as is
        cfg_write(2'd2, 8'd30);
        ata_data_i = 16'h3C96;
        do_access(1'b0, 5'h00, 16'h0, 1'b0, 0, 1'b0, 1'b0);
        // R8: ready held low across the end of the pulse
        ata_data_i = 16'h7E01;
        do_access(1'b0, 5'h02, 16'h0, 1'b0, 8, 1'b0, 1'b0);
        do_access(1'b1, 5'h0C, 16'hA1B2, 1'b1, 6, 1'b0, 1'b0);
        // R9, R11: start and timing write injected during a cycle
        do_access(1'b0, 5'h06, 16'h0, 1'b0, 0, 1'b1, 1'b0);
        // R9: the dropped write left the cycle register at 30
        do_access(1'b1, 5'h1C, 16'h0044, 1'b1, 0, 1'b0, 1'b0);
        // R9: timing write in the same clock as start is dropped
        do_access(1'b0, 5'h0A, 16'h0, 1'b0, 0, 1'b0, 1'b1);
        // R10: zero setup and pulse act as one clock; accepted write clears the flag
        cfg_write(2'd0, 8'd0);
        cfg_write(2'd1, 8'd0);
        cfg_write(2'd2, 8'd0);
        ata_data_i = 16'hFACE;
        do_access(1'b0, 5'h10, 16'h0, 1'b0, 0, 1'b0, 1'b0);
        do_access(1'b1, 5'h00, 16'hC0DE, 1'b0, 0, 1'b0, 1'b0);
        // R4, R6: hold longer than recovery is clipped at the cycle end
        cfg_write(2'd0, 8'd2);
        cfg_write(2'd1, 8'd3);
        cfg_write(2'd3, 8'd10);
        do_access(1'b1, 5'h1C, 16'h5566, 1'b0, 0, 1'b0, 1'b0);
        do_access(1'b0, 5'h08, 16'h0, 1'b1, 0, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL R2 watchdog: actual=timeout expected=completion");
        finish_run();
    end

endmodule